// File: doc/BRIEF.md
# Trap Control Coprocessor

This block holds the trap-handling state of a processor core and decides, every cycle, whether the core must divert to its trap handler. It keeps four registers: the exception program counter, a status word with the interrupt enables and privilege flags, a cause word with the exception code and the pending interrupt lines, and a record of the faulting data address. The core reads these registers by number through a combinational read port. It writes them through a single-cycle write port.

Eight hardware interrupt lines are sampled on every clock edge and shown as pending bits. The commit stage of the pipeline reports synchronous exceptions. Each report carries a 5-bit code, the PC of the instruction at the commit point, a delay-slot flag and an optional bad address. The block raises `trap_o` in the same cycle with the code of the winning cause, and on the next clock edge it records the trap state. A return-from-exception pulse leaves the handler's exception level.

Top module: `trap_ctrl`

## Requirements
- R1: After reset the status, cause, exception PC and bad-address registers all read 0 and `trap_o` is low.
- R2: Register number 8 reads the bad address, 12 reads status, 13 reads cause and 14 reads the exception PC. Every other number reads 0.
- R3: Only status bits 15:8 (interrupt mask, bit 8+n for line n), bit 4 (user mode), bit 1 (exception level) and bit 0 (global interrupt enable) can be written. All other status bits read 0.
- R4: A write to cause (13) or to the bad address (8) has no effect. A write to the exception PC (14) stores all 32 bits.
- R5: Cause bits 15:8 show `irq_i[7:0]` as sampled at the previous clock edge.
- R6: An interrupt is taken (`trap_o`=1, `trap_code_o`=0) only when (pending AND mask) is nonzero, status bit 0 is 1 and status bit 1 is 0.
- R7: A synchronous exception is always taken and takes priority over an interrupt in the same cycle. `trap_code_o` then equals `exc_code_i`, and that code is stored in cause bits 6:2.
- R8: Taking any trap sets status bit 1 and clears status bit 4 at the next edge.
- R9: If status bit 1 is 0 when a trap is taken, the exception PC gets `commit_pc_i` and cause bit 31 gets `commit_bd_i`. When `commit_bd_i` is 1, the exception PC gets `commit_pc_i` minus 4 (the branch address). If status bit 1 is already 1, both are left unchanged.
- R10: The bad-address register is loaded from `exc_bad_addr_i` only when the exception taken has code 4 (load or fetch address error) or code 5 (store address error).
- R11: `eret_i` clears status bit 1 and leaves the other registers unchanged. If a trap is taken in the same cycle, the trap wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Hardware interrupt lines |
| rd_addr_i | input | 5 | Register number to read |
| rd_data_o | output | 32 | Read data (combinational) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Register number to write |
| wr_data_i | input | 32 | Write data |
| exc_valid_i | input | 1 | Synchronous exception reported this cycle |
| exc_code_i | input | 5 | Exception code |
| commit_pc_i | input | 32 | PC of the instruction at the commit point |
| commit_bd_i | input | 1 | That instruction sits in a branch delay slot |
| exc_bad_addr_i | input | 32 | Faulting data address |
| eret_i | input | 1 | Return from exception |
| trap_o | output | 1 | Trap taken this cycle |
| trap_code_o | output | 5 | Code of the trap taken |

## Verification
The hardest case to produce is a second exception that arrives while the exception level is already set. In that case the code and the bad address must change, but the exception PC must keep the address of the first trap. The stimulus takes a syscall first, which also wins over an interrupt raised in the same cycle, and then reports a store address error before any return. The exception PC from the first trap is then read back. A separate sequence arms an interrupt and enables it one cycle before an exception report. This places the priority decision in a single cycle.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [4:0] REG_BADVA  = 5'd8;
  localparam logic [4:0] REG_STATUS = 5'd12;
  localparam logic [4:0] REG_CAUSE  = 5'd13;
  localparam logic [4:0] REG_EPC    = 5'd14;

  localparam int ST_IE   = 0;
  localparam int ST_EXL  = 1;
  localparam int ST_UM   = 4;
  localparam int IRQ_LO  = 8;
  localparam int CA_CODE = 2;
  localparam int CA_BD   = 31;
  localparam int CODE_W  = 5;

  typedef enum logic [CODE_W-1:0] {
    EXC_INT     = 5'd0,
    EXC_ADR_LD  = 5'd4,
    EXC_ADR_ST  = 5'd5,
    EXC_BUS_IF  = 5'd6,
    EXC_BUS_DAT = 5'd7,
    EXC_SYS     = 5'd8,
    EXC_BRK     = 5'd9,
    EXC_RSVD    = 5'd10,
    EXC_OVF     = 5'd12,
    EXC_TRAP    = 5'd13
  } exc_code_e;
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int NIRQ = 8
) (
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [NIRQ-1:0]   pend_i,
  input  logic [NIRQ-1:0]   mask_i,
  input  logic              ie_i,
  input  logic              exl_i,
  output logic              take_o,
  output logic [CODE_W-1:0] code_o
);
  logic irq_ok;

  always_comb begin
    irq_ok = (|(pend_i & mask_i)) & ie_i & ~exl_i;
    take_o = exc_valid_i | irq_ok;
    code_o = exc_valid_i ? exc_code_i : EXC_INT;
  end
endmodule

// File: rtl/trap_status_reg.sv
module trap_status_reg
  import trap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NIRQ   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              take_i,
  input  logic              eret_i,
  output logic [DATA_W-1:0] status_o
);
  localparam logic [DATA_W-1:0] WMASK =
      (DATA_W'({NIRQ{1'b1}}) << IRQ_LO) |
      (DATA_W'(1) << ST_UM) | (DATA_W'(1) << ST_EXL) | (DATA_W'(1) << ST_IE);

  logic [DATA_W-1:0] status_q, status_d;

  always_comb begin
    status_d = status_q;
    if (wr_en_i) status_d = wr_data_i & WMASK;
    if (eret_i) status_d[ST_EXL] = 1'b0;
    if (take_i) begin
      status_d[ST_EXL] = 1'b1;
      status_d[ST_UM]  = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_d;
  end

  assign status_o = status_q;
endmodule

// File: rtl/trap_capture.sv
module trap_capture
  import trap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NIRQ   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NIRQ-1:0]   irq_i,
  input  logic              take_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              exl_i,
  input  logic [DATA_W-1:0] pc_i,
  input  logic              bd_i,
  input  logic [DATA_W-1:0] bad_addr_i,
  input  logic              epc_wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] cause_o,
  output logic [DATA_W-1:0] epc_o,
  output logic [DATA_W-1:0] badva_o
);
  logic [NIRQ-1:0]   pend_q;
  logic [CODE_W-1:0] code_q;
  logic              bd_q;
  logic [DATA_W-1:0] epc_q, badva_q;
  logic              addr_err;

  assign addr_err = (code_i == EXC_ADR_LD) || (code_i == EXC_ADR_ST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      code_q  <= '0;
      bd_q    <= 1'b0;
      epc_q   <= '0;
      badva_q <= '0;
    end else begin
      pend_q <= irq_i;
      if (take_i) begin
        code_q <= code_i;
        if (addr_err) badva_q <= bad_addr_i;
      end
      // nested trap keeps the first restart point
      if (take_i && !exl_i) begin
        bd_q  <= bd_i;
        epc_q <= bd_i ? pc_i - DATA_W'(4) : pc_i;
      end else if (epc_wr_i) begin
        epc_q <= wr_data_i;
      end
    end
  end

  always_comb begin
    cause_o                   = '0;
    cause_o[CA_BD]            = bd_q;
    cause_o[IRQ_LO +: NIRQ]   = pend_q;
    cause_o[CA_CODE +: CODE_W] = code_q;
  end

  assign epc_o   = epc_q;
  assign badva_o = badva_q;
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NIRQ   = 8,
  parameter int RA_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NIRQ-1:0]   irq_i,
  input  logic [RA_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [RA_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              exc_valid_i,
  input  logic [CODE_W-1:0] exc_code_i,
  input  logic [DATA_W-1:0] commit_pc_i,
  input  logic              commit_bd_i,
  input  logic [DATA_W-1:0] exc_bad_addr_i,
  input  logic              eret_i,
  output logic              trap_o,
  output logic [CODE_W-1:0] trap_code_o
);
  logic [DATA_W-1:0] status_q, cause_q, epc_q, badva_q;
  logic              take;
  logic [CODE_W-1:0] take_code;
  logic              st_wr, epc_wr;

  assign st_wr  = wr_en_i && (wr_addr_i == RA_W'(REG_STATUS));
  assign epc_wr = wr_en_i && (wr_addr_i == RA_W'(REG_EPC));

  trap_arbiter #(.NIRQ(NIRQ)) u_arb (
    .exc_valid_i (exc_valid_i),
    .exc_code_i  (exc_code_i),
    .pend_i      (cause_q[IRQ_LO +: NIRQ]),
    .mask_i      (status_q[IRQ_LO +: NIRQ]),
    .ie_i        (status_q[ST_IE]),
    .exl_i       (status_q[ST_EXL]),
    .take_o      (take),
    .code_o      (take_code)
  );

  trap_status_reg #(.DATA_W(DATA_W), .NIRQ(NIRQ)) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (st_wr),
    .wr_data_i (wr_data_i),
    .take_i    (take),
    .eret_i    (eret_i),
    .status_o  (status_q)
  );

  trap_capture #(.DATA_W(DATA_W), .NIRQ(NIRQ)) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_i      (irq_i),
    .take_i     (take),
    .code_i     (take_code),
    .exl_i      (status_q[ST_EXL]),
    .pc_i       (commit_pc_i),
    .bd_i       (commit_bd_i),
    .bad_addr_i (exc_bad_addr_i),
    .epc_wr_i   (epc_wr),
    .wr_data_i  (wr_data_i),
    .cause_o    (cause_q),
    .epc_o      (epc_q),
    .badva_o    (badva_q)
  );

  always_comb begin
    case (rd_addr_i)
      RA_W'(REG_BADVA):  rd_data_o = badva_q;
      RA_W'(REG_STATUS): rd_data_o = status_q;
      RA_W'(REG_CAUSE):  rd_data_o = cause_q;
      RA_W'(REG_EPC):    rd_data_o = epc_q;
      default:           rd_data_o = '0;
    endcase
  end

  assign trap_o      = take;
  assign trap_code_o = take_code;
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk
  import trap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NIRQ   = 8,
  parameter int RA_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NIRQ-1:0]   irq_i,
  input logic              wr_en_i,
  input logic [RA_W-1:0]   wr_addr_i,
  input logic              exc_valid_i,
  input logic [CODE_W-1:0] exc_code_i,
  input logic              eret_i,
  input logic              trap_o,
  input logic [CODE_W-1:0] trap_code_o,
  input logic [DATA_W-1:0] status_i,
  input logic [DATA_W-1:0] cause_i,
  input logic [DATA_W-1:0] epc_i,
  input logic [DATA_W-1:0] badva_i
);
  logic epc_sw_wr;
  assign epc_sw_wr = wr_en_i && (wr_addr_i == RA_W'(REG_EPC));

  p_pend_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cause_i[IRQ_LO +: NIRQ] == $past(irq_i));

  p_exl_masks_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[ST_EXL] && !exc_valid_i) |-> !trap_o);

  p_exc_priority_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_valid_i |-> (trap_o && trap_code_o == exc_code_i));

  p_take_state_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> (status_i[ST_EXL] && !status_i[ST_UM]));

  p_epc_nested_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && status_i[ST_EXL] && !epc_sw_wr) |=> epc_i == $past(epc_i));

  p_badva_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(trap_o && (trap_code_o == EXC_ADR_LD || trap_code_o == EXC_ADR_ST))
      |=> badva_i == $past(badva_i));

  p_eret_clears_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && !trap_o) |=> !status_i[ST_EXL]);
endmodule

bind trap_ctrl trap_ctrl_chk #(.DATA_W(DATA_W), .NIRQ(NIRQ), .RA_W(RA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_i       (irq_i),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .exc_valid_i (exc_valid_i),
  .exc_code_i  (exc_code_i),
  .eret_i      (eret_i),
  .trap_o      (trap_o),
  .trap_code_o (trap_code_o),
  .status_i    (status_q),
  .cause_i     (cause_q),
  .epc_i       (epc_q),
  .badva_i     (badva_q)
);

// File: tb/trap_ctrl_bench.sv
`timescale 1ns/1ps
module trap_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  irq_i = '0;
  logic [4:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        wr_en_i = 1'b0;
  logic [4:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        exc_valid_i = 1'b0;
  logic [4:0]  exc_code_i = '0;
  logic [31:0] commit_pc_i = '0;
  logic        commit_bd_i = 1'b0;
  logic [31:0] exc_bad_addr_i = '0;
  logic        eret_i = 1'b0;
  logic        trap_o;
  logic [4:0]  trap_code_o;

  always #4 clk_i = ~clk_i;

  trap_ctrl u_trap_ctrl (.*);

  typedef struct {
    bit          is_trap;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  item_t       it;
  logic [31:0] act;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  // monitor: compare everything pushed at this falling edge
  always @(negedge clk_i) begin
    #2;
    while (sb_q.size() > 0) begin
      it  = sb_q.pop_front();
      act = it.is_trap ? {26'b0, trap_o, trap_code_o} : rd_data_o;
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic defaults();
    wr_en_i = 1'b0; exc_valid_i = 1'b0; eret_i = 1'b0; commit_bd_i = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_i); defaults();
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string tag);
    @(negedge clk_i); defaults();
    rd_addr_i = a;
    sb_q.push_back('{1'b0, e, tag});
  endtask

  task automatic trapchk(input bit t, input logic [4:0] c, input logic [31:0] pc,
                         input string tag);
    @(negedge clk_i); defaults();
    commit_pc_i = pc;
    sb_q.push_back('{1'b1, {26'b0, t, c}, tag});
  endtask

  task automatic exc(input logic [4:0] c, input logic [31:0] pc, input logic [31:0] bad,
                     input bit bd, input bit er, input logic [4:0] ec, input string tag);
    @(negedge clk_i); defaults();
    exc_valid_i = 1'b1; exc_code_i = c; commit_pc_i = pc; exc_bad_addr_i = bad;
    commit_bd_i = bd; eret_i = er;
    sb_q.push_back('{1'b1, {26'b0, 1'b1, ec}, tag});
  endtask

  task automatic set_irq(input logic [7:0] v);
    @(negedge clk_i); defaults(); irq_i = v;
  endtask

  task automatic eret();
    @(negedge clk_i); defaults(); eret_i = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state, R2 numbering
    rd(5'd8,  32'h0, "R1 badva");
    rd(5'd12, 32'h0, "R1 status");
    rd(5'd13, 32'h0, "R1 cause");
    rd(5'd14, 32'h0, "R1 epc");
    trapchk(1'b0, 5'd0, 32'h0, "R1 trap idle");
    rd(5'd3,  32'h0, "R2 unmapped");

    // R3 write mask, R4 read-only / writable
    wr(5'd12, 32'hFFFF_FFFF);
    rd(5'd12, 32'h0000_FF13, "R3 status mask");
    wr(5'd13, 32'hFFFF_FFFF);
    rd(5'd13, 32'h0, "R4 cause ignored");
    wr(5'd8, 32'h0000_1234);
    rd(5'd8, 32'h0, "R4 badva read-only");
    wr(5'd14, 32'hDEAD_BEE0);
    rd(5'd14, 32'hDEAD_BEE0, "R4 epc write");

    // R5 pending, R6 gating by mask
    wr(5'd12, 32'h0000_0401);
    set_irq(8'h02);
    rd(5'd13, 32'h0000_0200, "R5 pending");
    trapchk(1'b0, 5'd0, 32'h0, "R6 masked level");
    set_irq(8'h06);
    trapchk(1'b1, 5'd0, 32'h100, "R6 enabled level");
    rd(5'd12, 32'h0000_0403, "R8 exl set");
    rd(5'd13, 32'h0000_0600, "R5 cause after irq");
    rd(5'd14, 32'h0000_0100, "R9 epc irq");
    rd(5'd8,  32'h0, "R10 irq keeps badva");
    trapchk(1'b0, 5'd0, 32'h0, "R6 exl masks");

    // R11 return
    set_irq(8'h00);
    eret();
    rd(5'd12, 32'h0000_0401, "R11 exl cleared");
    rd(5'd14, 32'h0000_0100, "R11 epc kept");
    rd(5'd13, 32'h0, "R11 cause");

    // R6 global enable off
    wr(5'd12, 32'h0000_0400);
    set_irq(8'h04);
    trapchk(1'b0, 5'd0, 32'h0, "R6 ie off");
    rd(5'd13, 32'h0000_0400, "R5 pending ie off");

    // R7 exception beats interrupt in the same cycle
    wr(5'd12, 32'h0000_0401);
    exc(5'd8, 32'h200, 32'h0, 1'b0, 1'b0, 5'd8, "R7 syscall priority");
    rd(5'd13, 32'h0000_0420, "R7 code field");
    rd(5'd14, 32'h0000_0200, "R9 epc sync");
    rd(5'd8,  32'h0, "R10 syscall keeps badva");
    rd(5'd12, 32'h0000_0403, "R8 status after exc");

    // R9 nested: epc held, R10 store address error captured
    exc(5'd5, 32'h300, 32'hABC0_0001, 1'b0, 1'b0, 5'd5, "R7 nested trap");
    rd(5'd14, 32'h0000_0200, "R9 nested epc held");
    rd(5'd8,  32'hABC0_0001, "R10 store addr err");
    rd(5'd13, 32'h0000_0414, "R7 nested code");

    set_irq(8'h00);
    eret();
    rd(5'd12, 32'h0000_0401, "R11 second return");

    // R9 delay slot
    exc(5'd4, 32'h404, 32'h0000_0055, 1'b1, 1'b0, 5'd4, "R7 load addr err");
    rd(5'd14, 32'h0000_0400, "R9 bd epc");
    rd(5'd13, 32'h8000_0010, "R9 bd flag");
    rd(5'd8,  32'h0000_0055, "R10 load addr err");

    // R11 trap wins over eret, R8 clears user mode
    eret();
    wr(5'd12, 32'h0000_0411);
    rd(5'd12, 32'h0000_0411, "R3 user mode set");
    exc(5'd12, 32'h500, 32'h0000_0099, 1'b0, 1'b1, 5'd12, "R7 overflow");
    rd(5'd12, 32'h0000_0403, "R11 trap beats eret");
    rd(5'd8,  32'h0000_0055, "R10 overflow keeps badva");
    rd(5'd13, 32'h0000_0030, "R7 overflow code");
    rd(5'd14, 32'h0000_0500, "R9 epc overflow");

    @(negedge clk_i); defaults();
    #3;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule